// File: doc/BRIEF.md
# Radio-State GPIO Pin Controller

This block drives two banks of general-purpose pins, one for the receive side of a radio front end and one for the transmit side. Every pin is set on its own. It can be driven by a value that software writes, by a value taken from a small state table, or by one of two debug buses from the surrounding logic. The state table holds one receive-bank word and one transmit-bank word for each of four radio conditions. The condition in force is taken, cycle by cycle, from two live activity inputs. Pins in table mode therefore switch without software help whenever the radio starts or stops sending or listening.

Software programs the block through two plain 16-bit write ports. One port reaches the pin configuration registers and the other reaches the state table. Each port takes a word offset, and the registers sit on even offsets only. Each bank has a direction register that gates its outputs. A pin that is not set as an output drives 0 and has its enable low. Both the pin values and the pin enables leave the block through one register stage.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: While reset is held, and after it is released until the first write, all four pin outputs (both values and both enables) are 0.
- R2: A bank's output-enable bits equal that bank's direction register, and a pin whose direction bit is 0 drives 0. Writes to the state-table port never change an enable.
- R3: A pin with debug bit 0 and select bit 0 drives the bit from its bank's software value register.
- R4: A pin with debug bit 0 and select bit 1 drives the bit from the state-table word for its bank and the current radio condition.
- R5: A pin with debug bit 1 and select bit 0 drives the bit from its bank's debug bus 0.
- R6: A pin with debug bit 1 and select bit 1 drives the bit from its bank's debug bus 1.
- R7: The radio condition is decoded as {tx_active, rx_active}: 00 is idle (condition index 0), 10 is sending (index 1), 01 is listening (index 2), 11 is duplex (index 3). The table word for a condition sits at table offset 4*index for the receive bank and at 4*index+2 for the transmit bank.
- R8: The configuration offsets are 0 and 2 for the receive and transmit software values, 4 and 6 for the receive and transmit direction, 8 and 10 for select, and 12 and 14 for debug.
- R9: A write to an odd offset on either port changes no register. A bench that writes odd offsets sees that the pins keep their previous values and enables.
- R10: A change of tx_active, rx_active or a debug bus reaches the pins at the next rising clock edge. A register write sampled at one edge reaches the pins at the edge after it.
- R11: Pins within one bank take their sources independently, so a bank can mix all four sources in one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_we | input | 1 | Write strobe for the configuration registers |
| gpio_addr | input | 4 | Word offset for a configuration write |
| gpio_wdata | input | 16 | Configuration write data |
| atr_we | input | 1 | Write strobe for the state table |
| atr_addr | input | 4 | Word offset for a state-table write |
| atr_wdata | input | 16 | State-table write data |
| tx_active | input | 1 | Radio is sending |
| rx_active | input | 1 | Radio is listening |
| rx_dbg0 | input | 16 | Receive-bank debug bus 0 |
| rx_dbg1 | input | 16 | Receive-bank debug bus 1 |
| tx_dbg0 | input | 16 | Transmit-bank debug bus 0 |
| tx_dbg1 | input | 16 | Transmit-bank debug bus 1 |
| rx_pin_out | output | 16 | Receive-bank pin values |
| rx_pin_oe | output | 16 | Receive-bank output enables |
| tx_pin_out | output | 16 | Transmit-bank pin values |
| tx_pin_oe | output | 16 | Transmit-bank output enables |

## Verification
Two things can meet in the same cycle: a register write, on either port, and a change of the radio condition. The register path takes one edge longer than the condition path. The bench drives a select write, a table write and a flip of tx_active in one cycle. It then expects, one edge later, the new condition read through the old table and the old select bits. One edge after that it expects the full new configuration. Any mismatch in those two sampled cycles is a failed check, so the bench can tell a design where one path overtakes or delays the other.

// File: rtl/atr_gpio_pkg.sv
package atr_gpio_pkg;

    // eight registers per write port, on even word offsets
    localparam int REG_COUNT = 8;
    localparam int OFS_W     = $clog2(REG_COUNT) + 1;

    // configuration register indices (offset / 2); bank 0 = receive, 1 = transmit
    localparam int CFG_VAL = 0;
    localparam int CFG_DIR = 2;
    localparam int CFG_SEL = 4;
    localparam int CFG_DBG = 6;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_SEND   = 2'd1,
        RS_LISTEN = 2'd2,
        RS_DUPLEX = 2'd3
    } radio_state_e;

    // {debug bit, select bit}
    typedef enum logic [1:0] {
        SRC_SW    = 2'b00,
        SRC_TABLE = 2'b01,
        SRC_BUS0  = 2'b10,
        SRC_BUS1  = 2'b11
    } pin_src_e;

    function automatic radio_state_e decode_state(input logic tx, input logic rx);
        return radio_state_e'({rx, tx});
    endfunction

endpackage

// File: rtl/atr_gpio_regbank.sv
module atr_gpio_regbank
    import atr_gpio_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [OFS_W-1:0]              addr,
    input  logic [W-1:0]                  wdata,
    output logic [REG_COUNT-1:0][W-1:0]   regs
);
    localparam int IDX_W = OFS_W - 1;

    typedef struct packed {
        logic [REG_COUNT-1:0][W-1:0] r;
    } bank_t;

    bank_t            st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic             hit;

    always_comb begin
        st_d = st_q;
        idx  = addr[OFS_W-1:1];
        hit  = we && !addr[0];      // odd offsets are unmapped
        if (hit) begin
            st_d.r[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.r;

endmodule

// File: rtl/atr_gpio_tablesel.sv
module atr_gpio_tablesel
    import atr_gpio_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [REG_COUNT-1:0][W-1:0] table_regs,
    input  logic                        tx_active,
    input  logic                        rx_active,
    output logic [W-1:0]                rx_word,
    output logic [W-1:0]                tx_word
);
    radio_state_e state;

    always_comb begin
        state   = decode_state(tx_active, rx_active);
        rx_word = table_regs[{state, 1'b0}];
        tx_word = table_regs[{state, 1'b1}];
    end

endmodule

// File: rtl/atr_gpio_pinmux.sv
module atr_gpio_pinmux
    import atr_gpio_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] sw_val,
    input  logic [W-1:0] table_val,
    input  logic [W-1:0] bus0,
    input  logic [W-1:0] bus1,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] dbg_mode,
    output logic [W-1:0] drive
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        pin_src_e src;
        logic     pick;

        always_comb begin
            src = pin_src_e'({dbg_mode[p], sel[p]});
            unique case (src)
                SRC_SW:    pick = sw_val[p];
                SRC_TABLE: pick = table_val[p];
                SRC_BUS0:  pick = bus0[p];
                SRC_BUS1:  pick = bus1[p];
                default:   pick = 1'b0;
            endcase
        end

        assign drive[p] = pick & dir[p];
    end

endmodule

// File: rtl/atr_gpio_ctrl.sv
module atr_gpio_ctrl
    import atr_gpio_pkg::*;
#(
    parameter int PIN_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gpio_we,
    input  logic [OFS_W-1:0]   gpio_addr,
    input  logic [PIN_W-1:0]   gpio_wdata,
    input  logic               atr_we,
    input  logic [OFS_W-1:0]   atr_addr,
    input  logic [PIN_W-1:0]   atr_wdata,
    input  logic               tx_active,
    input  logic               rx_active,
    input  logic [PIN_W-1:0]   rx_dbg0,
    input  logic [PIN_W-1:0]   rx_dbg1,
    input  logic [PIN_W-1:0]   tx_dbg0,
    input  logic [PIN_W-1:0]   tx_dbg1,
    output logic [PIN_W-1:0]   rx_pin_out,
    output logic [PIN_W-1:0]   rx_pin_oe,
    output logic [PIN_W-1:0]   tx_pin_out,
    output logic [PIN_W-1:0]   tx_pin_oe
);
    localparam int BANKS = 2;

    typedef struct packed {
        logic [BANKS-1:0][PIN_W-1:0] val;
        logic [BANKS-1:0][PIN_W-1:0] oe;
    } pins_t;

    logic [REG_COUNT-1:0][PIN_W-1:0] cfg_regs;
    logic [REG_COUNT-1:0][PIN_W-1:0] tbl_regs;
    logic [BANKS-1:0][PIN_W-1:0]     tbl_word;
    logic [BANKS-1:0][PIN_W-1:0]     bus0;
    logic [BANKS-1:0][PIN_W-1:0]     bus1;
    logic [BANKS-1:0][PIN_W-1:0]     drive;

    pins_t pins_d, pins_q;

    atr_gpio_regbank #(.W(PIN_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpio_we),
        .addr  (gpio_addr),
        .wdata (gpio_wdata),
        .regs  (cfg_regs)
    );

    atr_gpio_regbank #(.W(PIN_W)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (atr_we),
        .addr  (atr_addr),
        .wdata (atr_wdata),
        .regs  (tbl_regs)
    );

    atr_gpio_tablesel #(.W(PIN_W)) u_sel (
        .table_regs (tbl_regs),
        .tx_active  (tx_active),
        .rx_active  (rx_active),
        .rx_word    (tbl_word[0]),
        .tx_word    (tbl_word[1])
    );

    assign bus0 = {tx_dbg0, rx_dbg0};
    assign bus1 = {tx_dbg1, rx_dbg1};

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        atr_gpio_pinmux #(.W(PIN_W)) u_mux (
            .sw_val    (cfg_regs[CFG_VAL + b]),
            .table_val (tbl_word[b]),
            .bus0      (bus0[b]),
            .bus1      (bus1[b]),
            .dir       (cfg_regs[CFG_DIR + b]),
            .sel       (cfg_regs[CFG_SEL + b]),
            .dbg_mode  (cfg_regs[CFG_DBG + b]),
            .drive     (drive[b])
        );
    end

    always_comb begin
        pins_d     = pins_q;
        pins_d.val = drive;
        pins_d.oe  = {cfg_regs[CFG_DIR + 1], cfg_regs[CFG_DIR]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign rx_pin_out = pins_q.val[0];
    assign tx_pin_out = pins_q.val[1];
    assign rx_pin_oe  = pins_q.oe[0];
    assign tx_pin_oe  = pins_q.oe[1];

endmodule

// File: rtl/atr_gpio_ctrl_chk.sv
module atr_gpio_ctrl_chk #(
    parameter int PIN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gpio_we,
    input logic             atr_we,
    input logic             tx_active,
    input logic             rx_active,
    input logic [PIN_W-1:0] rx_dbg0,
    input logic [PIN_W-1:0] rx_dbg1,
    input logic [PIN_W-1:0] tx_dbg0,
    input logic [PIN_W-1:0] tx_dbg1,
    input logic [PIN_W-1:0] rx_pin_out,
    input logic [PIN_W-1:0] rx_pin_oe,
    input logic [PIN_W-1:0] tx_pin_out,
    input logic [PIN_W-1:0] tx_pin_oe
);
    AST_RX_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pin_out & ~rx_pin_oe) == '0); // R2

    AST_TX_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pin_out & ~tx_pin_oe) == '0); // R2

    AST_OE_ONLY_FROM_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gpio_we, 2) |-> ($stable(rx_pin_oe) && $stable(tx_pin_oe))); // R2

    AST_PINS_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(gpio_we, 2) && !$past(atr_we, 2)
         && $past(tx_active) == $past(tx_active, 2)
         && $past(rx_active) == $past(rx_active, 2)
         && $past(rx_dbg0) == $past(rx_dbg0, 2)
         && $past(rx_dbg1) == $past(rx_dbg1, 2)
         && $past(tx_dbg0) == $past(tx_dbg0, 2)
         && $past(tx_dbg1) == $past(tx_dbg1, 2))
        |-> ($stable(rx_pin_out) && $stable(tx_pin_out))); // R10

endmodule

bind atr_gpio_ctrl atr_gpio_ctrl_chk #(.PIN_W(PIN_W)) chk_i (.*);

// File: tb/atr_gpio_ctrl_tb_top.sv
module atr_gpio_ctrl_tb_top;
    import atr_gpio_pkg::*;

    localparam int W = 16;
    localparam int HALF_PERIOD = 5; // 10 ns period, 100 MHz

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         gpio_we = 1'b0;
    logic [OFS_W-1:0] gpio_addr = '0;
    logic [W-1:0] gpio_wdata = '0;
    logic         atr_we = 1'b0;
    logic [OFS_W-1:0] atr_addr = '0;
    logic [W-1:0] atr_wdata = '0;
    logic         tx_active = 1'b0;
    logic         rx_active = 1'b0;
    logic [W-1:0] rx_dbg0 = 16'hA5C3;
    logic [W-1:0] rx_dbg1 = 16'h0FF0;
    logic [W-1:0] tx_dbg0 = 16'h3C69;
    logic [W-1:0] tx_dbg1 = 16'hF00F;
    logic [W-1:0] rx_pin_out, rx_pin_oe, tx_pin_out, tx_pin_oe;

    always #HALF_PERIOD clk = ~clk;

    atr_gpio_ctrl #(.PIN_W(W)) dut_i (.*);

    typedef struct {
        logic [W-1:0] rxo;
        logic [W-1:0] rxe;
        logic [W-1:0] txo;
        logic [W-1:0] txe;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;
    logic [W-1:0] cm[8];   // configuration model
    logic [W-1:0] tm[8];   // table model

    function automatic logic [W-1:0] model_bank(int b);
        logic [W-1:0] r;
        int           cond;
        logic [W-1:0] d0, d1, tw;
        cond = (rx_active ? 2 : 0) + (tx_active ? 1 : 0);
        tw   = tm[cond * 2 + b];
        d0   = (b == 0) ? rx_dbg0 : tx_dbg0;
        d1   = (b == 0) ? rx_dbg1 : tx_dbg1;
        for (int i = 0; i < W; i++) begin
            case ({cm[6 + b][i], cm[4 + b][i]})
                2'b00:   r[i] = cm[b][i];
                2'b01:   r[i] = tw[i];
                2'b10:   r[i] = d0[i];
                default: r[i] = d1[i];
            endcase
            r[i] = r[i] & cm[2 + b][i];
        end
        return r;
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.rxo = model_bank(0);
        e.txo = model_bank(1);
        e.rxe = cm[2];
        e.txe = cm[3];
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic chk(string tag);
        @(negedge clk);
        push(tag);
    endtask

    task automatic wr_cfg(int ofs, logic [W-1:0] d);
        @(negedge clk);
        gpio_we = 1'b1; gpio_addr = OFS_W'(ofs); gpio_wdata = d;
        @(negedge clk);
        gpio_we = 1'b0;
        if (ofs % 2 == 0) cm[ofs / 2] = d;
    endtask

    task automatic wr_tbl(int ofs, logic [W-1:0] d);
        @(negedge clk);
        atr_we = 1'b1; atr_addr = OFS_W'(ofs); atr_wdata = d;
        @(negedge clk);
        atr_we = 1'b0;
        if (ofs % 2 == 0) tm[ofs / 2] = d;
    endtask

    task automatic set_cond(logic tx, logic rx);
        @(negedge clk);
        tx_active = tx; rx_active = rx;
    endtask

    // monitor: pops the scoreboard shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (rx_pin_out !== e.rxo || rx_pin_oe !== e.rxe ||
                    tx_pin_out !== e.txo || tx_pin_oe !== e.txe) begin
                    n_fail++;
                    $display("FAIL %s: got rx %h/%h tx %h/%h, expected rx %h/%h tx %h/%h",
                             e.tag, rx_pin_out, rx_pin_oe, tx_pin_out, tx_pin_oe,
                             e.rxo, e.rxe, e.txo, e.txe);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            cm[k] = '0;
            tm[k] = '0;
        end

        // R1: reset state, during and just after reset
        repeat (3) @(negedge clk);
        push("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 after release");

        // R8, R3: software values with all pins as outputs
        wr_cfg(0, 16'hA5A5);
        wr_cfg(2, 16'h3C3C);
        wr_cfg(4, 16'hFFFF);
        wr_cfg(6, 16'hFFFF);
        chk("R3 R8 software drive");

        // R2: partial direction masks the value
        wr_cfg(4, 16'h00FF);
        wr_cfg(6, 16'hF0F0);
        chk("R2 direction mask");
        wr_cfg(4, 16'hFFFF);
        wr_cfg(6, 16'hFFFF);

        // R4, R7: fill the table, select table source, walk conditions
        for (int k = 0; k < 8; k++) wr_tbl(k * 2, 16'h1357 ^ W'(k * 16'h1111) ^ W'(k << 13));
        // R2: table writes left enables untouched
        chk("R2 table writes keep enables");
        wr_cfg(8, 16'hFFFF);
        wr_cfg(10, 16'hFFFF);
        chk("R4 R7 idle");
        set_cond(1'b1, 1'b0); chk("R4 R7 sending");
        set_cond(1'b0, 1'b1); chk("R4 R7 listening");
        set_cond(1'b1, 1'b1); chk("R4 R7 duplex");
        set_cond(1'b0, 1'b0); chk("R4 R7 back to idle");

        // R9: odd offsets on both ports change nothing
        wr_cfg(5, 16'h0000);
        wr_tbl(3, 16'hDEAD);
        chk("R9 odd offsets ignored");

        // R5, R6: debug buses
        wr_cfg(12, 16'hFFFF);
        wr_cfg(14, 16'hFFFF);
        chk("R6 debug bus 1");
        wr_cfg(8, 16'h0000);
        wr_cfg(10, 16'h0000);
        chk("R5 debug bus 0");

        // R10: debug bus change reaches pins one edge later
        @(negedge clk);
        push("R10 before bus edge");
        rx_dbg0 = 16'h6E17; tx_dbg0 = 16'h91C2;
        chk("R10 bus change one edge");

        // R11: mixed sources in one word
        wr_cfg(0, 16'h5A96);
        wr_cfg(2, 16'hC3E1);
        wr_cfg(12, 16'hF0F0);
        wr_cfg(14, 16'h0FF0);
        wr_cfg(8, 16'hCCCC);
        wr_cfg(10, 16'hAAAA);
        set_cond(1'b1, 1'b0);
        chk("R11 mixed sources");

        // R10: condition change reaches pins one edge later
        @(negedge clk);
        push("R10 before condition edge");
        tx_active = 1'b0; rx_active = 1'b1;
        chk("R10 condition one edge");

        // R10: a register write takes two edges
        @(negedge clk);
        gpio_we = 1'b1; gpio_addr = 4'd0; gpio_wdata = 16'h0001;
        @(negedge clk);
        gpio_we = 1'b0;
        push("R10 write not yet on pins");
        cm[0] = 16'h0001;
        chk("R10 write on pins");

        // same cycle: select write, table write and condition flip together
        @(negedge clk);
        gpio_we = 1'b1; gpio_addr = 4'd8; gpio_wdata = 16'hFFFF;
        atr_we  = 1'b1; atr_addr  = 4'd4; atr_wdata  = 16'hBEEF;
        tx_active = 1'b1; rx_active = 1'b0;
        @(negedge clk);
        gpio_we = 1'b0; atr_we = 1'b0;
        push("R10 R4 new condition old registers");
        cm[4] = 16'hFFFF; tm[2] = 16'hBEEF;
        chk("R10 R4 new condition new registers");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule